// File: doc/BRIEF.md
# Dual Down-Counter Timer with Shared Interrupt

This block holds two independent 32-bit down-counters behind a small word-addressed register bus. Each counter has a reload (divider) register and a control register. The control register picks an operation: load the divider into the counter, freeze the counter, or count continuously with automatic reload. It also picks which of eight tick strobes drives the counter. The strobes come from elsewhere in the chip as single-cycle enables, one for each rate domain. Higher select codes carry the faster sources, in the order of about 29.5 MHz, 32 MHz, 32.768 MHz and 100 MHz for codes 4 to 7.

When a running counter decrements to zero, it sets its own bit in a shared status register. Software gates the status bits with a mask register and clears them through an acknowledge register. A single interrupt line is the OR of the masked status. A free-running cycle counter can also be read, so software can take timestamps.

Top module: `dual_tick_timer`

## Requirements
- R1: When reset is held low at a clock edge, every register (dividers, counts, controls, mask, status, time) reads zero after that edge, and `irq` is low.
- R2: Writing a control value whose bits [1:0] equal 0 (load) copies that timer's divider into its count on the same edge. The count then stays put, because load does not count.
- R3: With bits [1:0] equal 2 (run), the count drops by one on each edge where the tick strobe selected by control bits [4:2] (bit index of `tick_src`) is high. Strobes on other sources have no effect.
- R4: A running count that steps from 1 to 0 sets status bit 0 (timer 0) or bit 1 (timer 1) on that same edge. The next selected tick at zero reloads the divider, so the period is divider+1 ticks. A divider of 0 never sets status.
- R5: Operation 1 (hold) and the reserved operation 3 both freeze the count, whatever ticks arrive.
- R6: Writing the acknowledge register clears each status bit whose data bit is 1 and leaves bits written 0 alone. An expiry on the same edge wins over the clear.
- R7: `irq` is high exactly when (status AND mask) is non-zero. It follows a mask write from the edge that stores it.
- R8: The time register counts up by one on every clock edge after reset is released.
- R9: `bus_addr` is a word index (byte offset / 4). The byte offsets are: divider 0x00/0x10, count 0x04/0x14 (read only), control 0x08/0x18 (5 bits), time 0x38, mask 0x48, acknowledge 0x4C (reads 0), status 0x50 (2 bits). Any other address reads 0 and ignores writes.
- R10: The two timers are independent. Ticks, writes and expiry of one leave the other's count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 5 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_src | input | 8 | Single-cycle tick enables, one per source |
| irq | output | 1 | OR of masked status |

## Verification
A count that is wrong by one shows up at the status register and on `irq` one selected tick early or late. It is visible at the count read-back on the very edge it goes wrong. A lost clear or a wrongly ordered ack-versus-expiry update leaves a status bit that disagrees with the model on the edge after the acknowledge write. Wrong source decoding shows as counts moving on unselected strobes within one cycle. The random phase mixes all sources, modes and register writes, so these show within a few cycles of their cause.

// File: rtl/dtt_pkg.sv
// Package: shared constants, operation codes and register word indices
// for the dual down-counter timer. Assumes a 5-bit word index bus.
package dtt_pkg;
    localparam int NUM_TMR    = 2;
    localparam int ADDR_W     = 5;
    localparam int OP_W       = 2;
    localparam int TMR_STRIDE = 4;
    localparam int SLOT_DIV   = 0;
    localparam int SLOT_CNT   = 1;
    localparam int SLOT_CTRL  = 2;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD = 2'd0,
        OP_HOLD = 2'd1,
        OP_RUN  = 2'd2,
        OP_RSVD = 2'd3
    } tmr_op_e;

    localparam logic [ADDR_W-1:0] A_TIME = 5'd14;
    localparam logic [ADDR_W-1:0] A_MASK = 5'd18;
    localparam logic [ADDR_W-1:0] A_ACK  = 5'd19;
    localparam logic [ADDR_W-1:0] A_STAT = 5'd20;

    // Word index of a per-timer register slot.
    function automatic logic [ADDR_W-1:0] tmr_word(input int t, input int slot);
        return ADDR_W'(t * TMR_STRIDE + slot);
    endfunction
endpackage

// File: rtl/dtt_counter.sv
// Module: one down-counter with divider and control registers.
// Assumes the divider and control writes never occur on the same cycle
// (distinct addresses). A control write takes priority over a tick.
module dtt_counter
    import dtt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SEL_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    div_wr,
    input  logic                    ctrl_wr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [(1<<SEL_W)-1:0]   tick_src,
    output logic [DATA_W-1:0]       div_q,
    output logic [DATA_W-1:0]       cnt_q,
    output logic [OP_W+SEL_W-1:0]   ctrl_q,
    output logic                    expire
);
    localparam int CTRL_W = OP_W + SEL_W;

    tmr_op_e            op;
    logic [SEL_W-1:0]   sel;
    logic               tick;
    logic               running;

    assign op      = tmr_op_e'(ctrl_q[OP_W-1:0]);
    assign sel     = ctrl_q[CTRL_W-1:OP_W];
    assign tick    = tick_src[sel];
    assign running = (op == OP_RUN) && !ctrl_wr;
    assign expire  = running && tick && (cnt_q == DATA_W'(1));

    // Divider register: plain storage of the reload value.
    always_ff @(posedge clk) begin
        if (!rst_n)      div_q <= '0;
        else if (div_wr) div_q <= wdata;
    end

    // Control register: operation and tick source select.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= wdata[CTRL_W-1:0];
    end

    // Count: load on a load write, reload at zero or decrement on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ctrl_wr) begin
            if (tmr_op_e'(wdata[OP_W-1:0]) == OP_LOAD) cnt_q <= div_q;
        end else if (running && tick) begin
            if (cnt_q == '0) cnt_q <= div_q;
            else             cnt_q <= cnt_q - DATA_W'(1);
        end
    end
endmodule

// File: rtl/dtt_irq_ctrl.sv
// Module: shared status, mask and acknowledge logic with the combined
// interrupt. Assumes expire pulses last one cycle; expiry beats a clear.
module dtt_irq_ctrl #(
    parameter int NUM_TMR = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_TMR-1:0] expire,
    input  logic               mask_wr,
    input  logic               ack_wr,
    input  logic [NUM_TMR-1:0] wbits,
    output logic [NUM_TMR-1:0] status_q,
    output logic [NUM_TMR-1:0] mask_q,
    output logic               irq
);
    // Status bits: one sticky flag per timer.
    for (genvar i = 0; i < NUM_TMR; i++) begin : g_stat
        always_ff @(posedge clk) begin
            if (!rst_n)                  status_q[i] <= 1'b0;
            else if (expire[i])          status_q[i] <= 1'b1;
            else if (ack_wr && wbits[i]) status_q[i] <= 1'b0;
        end
    end

    // Mask register: enables each status bit onto the interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= wbits;
    end

    assign irq = |(status_q & mask_q);
endmodule

// File: rtl/dtt_time_base.sv
// Module: free-running cycle counter for timestamps; wraps silently.
module dtt_time_base #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [DATA_W-1:0] time_q
);
    // Count every clock after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) time_q <= '0;
        else        time_q <= time_q + DATA_W'(1);
    end
endmodule

// File: rtl/dual_tick_timer.sv
// Module: top of the dual down-counter timer. Decodes the word-addressed
// bus, instances one counter per timer, the interrupt logic and the
// time base, and drives a combinational read mux.
module dual_tick_timer
    import dtt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SEL_W  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [(1<<SEL_W)-1:0] tick_src,
    output logic                  irq
);
    localparam int CTRL_W = OP_W + SEL_W;

    logic [NUM_TMR-1:0]                div_wr;
    logic [NUM_TMR-1:0]                ctrl_wr;
    logic [NUM_TMR-1:0]                expire;
    logic [NUM_TMR-1:0][DATA_W-1:0]    div_q;
    logic [NUM_TMR-1:0][DATA_W-1:0]    cnt_q;
    logic [NUM_TMR-1:0][CTRL_W-1:0]    ctrl_q;
    logic [NUM_TMR-1:0][OP_W-1:0]      tmr_op_q;
    logic [NUM_TMR-1:0]                status_q;
    logic [NUM_TMR-1:0]                mask_q;
    logic [DATA_W-1:0]                 time_q;

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        assign div_wr[t]   = bus_wr && (bus_addr == tmr_word(t, SLOT_DIV));
        assign ctrl_wr[t]  = bus_wr && (bus_addr == tmr_word(t, SLOT_CTRL));
        assign tmr_op_q[t] = ctrl_q[t][OP_W-1:0];

        dtt_counter #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_counter (
            .clk      (clk),
            .rst_n    (rst_n),
            .div_wr   (div_wr[t]),
            .ctrl_wr  (ctrl_wr[t]),
            .wdata    (bus_wdata),
            .tick_src (tick_src),
            .div_q    (div_q[t]),
            .cnt_q    (cnt_q[t]),
            .ctrl_q   (ctrl_q[t]),
            .expire   (expire[t])
        );
    end

    dtt_irq_ctrl #(.NUM_TMR(NUM_TMR)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire   (expire),
        .mask_wr  (bus_wr && (bus_addr == A_MASK)),
        .ack_wr   (bus_wr && (bus_addr == A_ACK)),
        .wbits    (bus_wdata[NUM_TMR-1:0]),
        .status_q (status_q),
        .mask_q   (mask_q),
        .irq      (irq)
    );

    dtt_time_base #(.DATA_W(DATA_W)) u_time (
        .clk    (clk),
        .rst_n  (rst_n),
        .time_q (time_q)
    );

    // Read mux: unmapped words and the acknowledge word read zero.
    always_comb begin
        bus_rdata = '0;
        for (int t = 0; t < NUM_TMR; t++) begin
            if (bus_addr == tmr_word(t, SLOT_DIV))  bus_rdata = div_q[t];
            if (bus_addr == tmr_word(t, SLOT_CNT))  bus_rdata = cnt_q[t];
            if (bus_addr == tmr_word(t, SLOT_CTRL)) bus_rdata = DATA_W'(ctrl_q[t]);
        end
        if (bus_addr == A_TIME) bus_rdata = time_q;
        if (bus_addr == A_MASK) bus_rdata = DATA_W'(mask_q);
        if (bus_addr == A_STAT) bus_rdata = DATA_W'(status_q);
    end
endmodule

// File: rtl/dtt_checker.sv
// Module: property checker for the dual down-counter timer, bound to the
// top. Observes ports and the signals between counters and irq logic.
module dtt_checker
    import dtt_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_T   = 2
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_wr,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [NUM_T-1:0]              ack_bits,
    input logic                          irq,
    input logic [NUM_T-1:0]              expire,
    input logic [NUM_T-1:0]              status_q,
    input logic [NUM_T-1:0]              mask_q,
    input logic [NUM_T-1:0][DATA_W-1:0]  cnt_q,
    input logic [NUM_T-1:0][OP_W-1:0]    tmr_op_q,
    input logic [NUM_T-1:0]              ctrl_wr,
    input logic [DATA_W-1:0]             time_q
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!irq && status_q == '0 && mask_q == '0)); // R1

    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(expire) != '0 || $past(bus_wr && bus_addr == A_MASK))); // R7

    AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (time_q == $past(time_q) + DATA_W'(1))); // R8

    for (genvar t = 0; t < NUM_T; t++) begin : g_chk
        AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            expire[t] |=> status_q[t]); // R4

        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == A_ACK && ack_bits[t] && !expire[t]) |=> !status_q[t]); // R6

        AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
            ((tmr_op_q[t] == OP_HOLD || tmr_op_q[t] == OP_RSVD) && !ctrl_wr[t])
            |=> $stable(cnt_q[t])); // R5
    end
endmodule

bind dual_tick_timer dtt_checker #(.DATA_W(DATA_W), .NUM_T(dtt_pkg::NUM_TMR)) u_dtt_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .ack_bits (bus_wdata[dtt_pkg::NUM_TMR-1:0]),
    .irq      (irq),
    .expire   (expire),
    .status_q (status_q),
    .mask_q   (mask_q),
    .cnt_q    (cnt_q),
    .tmr_op_q (tmr_op_q),
    .ctrl_wr  (ctrl_wr),
    .time_q   (time_q)
);

// File: tb/dual_tick_timer_bench.sv
`timescale 1ns/1ps
module dual_tick_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  tick_src = '0;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    // Requirement-derived model state.
    logic [31:0] m_div  [2];
    logic [31:0] m_cnt  [2];
    logic [4:0]  m_ctrl [2];
    logic [1:0]  m_stat;
    logic [1:0]  m_mask;
    logic [31:0] m_time;

    always #10 clk = ~clk;

    dual_tick_timer u_dual_tick_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_src(tick_src), .irq(irq)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Next state per the requirements for one clock edge.
    task automatic model_step(input logic wr, input logic [4:0] a,
                              input logic [31:0] d, input logic [7:0] tk, input logic rs);
        logic [1:0] ex;
        logic cw, dw;
        if (!rs) begin
            for (int t = 0; t < 2; t++) begin
                m_div[t] = '0; m_cnt[t] = '0; m_ctrl[t] = '0;
            end
            m_stat = '0; m_mask = '0; m_time = '0;
            return;
        end
        ex = '0;
        for (int t = 0; t < 2; t++) begin
            cw = wr && (a == 5'(4*t + 2));
            dw = wr && (a == 5'(4*t));
            if (cw) begin
                if (d[1:0] == 2'd0) m_cnt[t] = m_div[t];
            end else if (m_ctrl[t][1:0] == 2'd2 && tk[m_ctrl[t][4:2]]) begin
                if (m_cnt[t] == 0) m_cnt[t] = m_div[t];
                else begin
                    if (m_cnt[t] == 1) ex[t] = 1'b1;
                    m_cnt[t] = m_cnt[t] - 1;
                end
            end
            if (cw) m_ctrl[t] = d[4:0];
            if (dw) m_div[t] = d;
        end
        for (int i = 0; i < 2; i++) begin
            if (ex[i]) m_stat[i] = 1'b1;
            else if (wr && a == 5'd19 && d[i]) m_stat[i] = 1'b0;
        end
        if (wr && a == 5'd18) m_mask = d[1:0];
        m_time = m_time + 1;
    endtask

    function automatic logic [31:0] exp_rd(input logic [4:0] a);
        case (a)
            5'd0:  return m_div[0];
            5'd1:  return m_cnt[0];
            5'd2:  return {27'b0, m_ctrl[0]};
            5'd4:  return m_div[1];
            5'd5:  return m_cnt[1];
            5'd6:  return {27'b0, m_ctrl[1]};
            5'd14: return m_time;
            5'd18: return {30'b0, m_mask};
            5'd20: return {30'b0, m_stat};
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(input logic [4:0] a);
        if (!rst_n) return "R1";
        case (a)
            5'd0, 5'd1, 5'd2, 5'd4, 5'd5, 5'd6: return "R3";
            5'd14: return "R8";
            5'd18: return "R7";
            5'd20: return "R4";
            default: return "R9";
        endcase
    endfunction

    // One clock: drive at the falling edge, compare at the next one.
    task automatic cycle(input logic wr, input logic [4:0] a,
                         input logic [31:0] d, input logic [7:0] tk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; tick_src = tk;
        model_step(wr, a, d, tk, rst_n);
        @(negedge clk);
        check(tag_of(a), "rdata", bus_rdata, exp_rd(a));
        check("R7", "irq", {31'b0, irq}, {31'b0, |(m_stat & m_mask)});
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        cycle(1'b1, a, d, 8'h00);
    endtask

    task automatic rd(input logic [4:0] a);
        cycle(1'b0, a, 32'h0, 8'h00);
    endtask

    task automatic ticks(input int n, input logic [7:0] tk);
        for (int i = 0; i < n; i++) cycle(1'b0, 5'd1, 32'h0, tk);
    endtask

    initial begin
        logic [31:0] t0;
        logic [4:0]  a;
        logic [31:0] d;
        void'($urandom(32'd20240611));
        @(negedge clk);
        for (int i = 0; i < 3; i++) rd(5'd20);
        rst_n = 1'b1;
        // R1: reset state
        rd(5'd20); check("R1", "status after reset", bus_rdata, 32'h0);
        rd(5'd1);  check("R1", "count0 after reset", bus_rdata, 32'h0);
        check("R1", "irq after reset", {31'b0, irq}, 32'h0);
        // R2: load
        wr(5'd0, 32'd5); wr(5'd2, 32'd0);
        rd(5'd1); check("R2", "count0 after load", bus_rdata, 32'd5);
        ticks(2, 8'h01); rd(5'd1); check("R2", "load does not count", bus_rdata, 32'd5);
        // R3: run on source 5
        wr(5'd18, 32'd1); wr(5'd2, 32'd22);
        ticks(3, 8'h20); rd(5'd1); check("R3", "three ticks", bus_rdata, 32'd2);
        ticks(3, 8'h10); rd(5'd1); check("R3", "other source ignored", bus_rdata, 32'd2);
        // R4: expiry and reload
        ticks(2, 8'h20); rd(5'd20); check("R4", "status bit0 set", bus_rdata, 32'd1);
        check("R7", "irq with mask", {31'b0, irq}, 32'd1);
        rd(5'd1); check("R4", "count at zero", bus_rdata, 32'd0);
        ticks(1, 8'h20); rd(5'd1); check("R4", "reload", bus_rdata, 32'd5);
        // R6: acknowledge
        wr(5'd19, 32'd2); rd(5'd20); check("R6", "ack bit1 keeps bit0", bus_rdata, 32'd1);
        ticks(4, 8'h20);
        cycle(1'b1, 5'd19, 32'd1, 8'h20);
        rd(5'd20); check("R6", "expiry beats ack", bus_rdata, 32'd1);
        wr(5'd19, 32'd1); rd(5'd20); check("R6", "ack clears", bus_rdata, 32'd0);
        check("R6", "irq after ack", {31'b0, irq}, 32'd0);
        // R5: hold and reserved op
        ticks(3, 8'h20); rd(5'd1); check("R5", "count before hold", bus_rdata, 32'd3);
        wr(5'd2, 32'd23); ticks(3, 8'h20); rd(5'd1); check("R5", "op3 freezes", bus_rdata, 32'd3);
        wr(5'd2, 32'd21); ticks(3, 8'h20); rd(5'd1); check("R5", "op1 freezes", bus_rdata, 32'd3);
        // R4: divider zero never expires
        wr(5'd2, 32'd22);
        wr(5'd4, 32'd0); wr(5'd6, 32'd2); ticks(5, 8'h01);
        rd(5'd20); check("R4", "zero divider no status", bus_rdata, 32'd0);
        rd(5'd5);  check("R4", "zero divider count", bus_rdata, 32'd0);
        // R7 and R10: timer1 expires unmasked, timer0 untouched
        wr(5'd4, 32'd1); ticks(2, 8'h01);
        rd(5'd20); check("R7", "status bit1", bus_rdata, 32'd2);
        check("R7", "irq masked off", {31'b0, irq}, 32'd0);
        rd(5'd1); check("R10", "timer0 unaffected", bus_rdata, 32'd3);
        wr(5'd18, 32'd3); check("R7", "irq after mask write", {31'b0, irq}, 32'd1);
        wr(5'd19, 32'd2);
        // R8: time base
        rd(5'd14); t0 = bus_rdata;
        for (int i = 0; i < 7; i++) rd(5'd0);
        rd(5'd14); check("R8", "time delta", bus_rdata, t0 + 32'd8);
        // R9: map
        wr(5'd3, 32'hFFFF); rd(5'd3); check("R9", "unmapped reads zero", bus_rdata, 32'd0);
        rd(5'd19); check("R9", "ack reads zero", bus_rdata, 32'd0);
        rd(5'd2);  check("R9", "ctrl0 readback", bus_rdata, 32'd22);
        // Random phase, model-checked every cycle.
        for (int i = 0; i < 3000; i++) begin
            case ($urandom % 12)
                0: a = 5'd0;  1: a = 5'd1;  2: a = 5'd2;  3: a = 5'd4;
                4: a = 5'd5;  5: a = 5'd6;  6: a = 5'd14; 7: a = 5'd18;
                8: a = 5'd19; 9: a = 5'd20; 10: a = 5'd3; default: a = 5'd31;
            endcase
            case (a)
                5'd0, 5'd4: d = 32'($urandom_range(0, 6));
                5'd2, 5'd6: d = 32'($urandom % 32);
                5'd3, 5'd31: d = $urandom;
                default: d = 32'($urandom % 4);
            endcase
            cycle(($urandom % 5) < 2, a, d, 8'($urandom & $urandom));
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule